// File: doc/BRIEF.md
# ADC Start-of-Conversion Delay Timer

This block is one timer channel whose only job is to start ADC conversions. It raises a single-cycle trigger pulse, `adc_start`, and that pulse is what launches a conversion. The channel works in one of two modes, selected by a one-bit mode input.

In free-running mode the channel counts up to a programmed period, fires, and starts again, so the ADC is sampled at a fixed rate with no outside help. In PWM-locked mode the channel sits idle until the PWM module sends its reload sync pulse. It then counts a programmable number of delay cycles and fires once. This lets the conversion land at a chosen point inside each PWM cycle. A sync that arrives while a delay is still running restarts that delay.

An enable input holds both counters at zero and suppresses all triggers while it is low. All control inputs are plain level signals sampled on every clock. There is no data stream, so the block has no valid/ready handshake.

Top module: `adc_trig_delay_timer`

## Requirements
- R1: With `mode_sel`=0 (free-running) and `tmr_en`=1, `adc_start` is high in exactly one sample per `period_val`+1 cycles. The first pulse is sampled `period_val`+1 cycles after the cycle in which enable was driven high.
- R2: A `period_val` of 0 behaves as a period of 1, so pulses come every 2 cycles.
- R3: With `mode_sel`=1 (PWM-locked), a `pwm_sync` high in cycle c, with delay value D, makes `adc_start` high in cycle c+D+1 only.
- R4: With a delay of 0, `adc_start` is high in the cycle immediately after the sync cycle.
- R5: A `pwm_sync` arriving while a delay is counting discards the count in progress and restarts the delay from the new sync. Only the restarted delay produces a pulse.
- R6: In PWM-locked mode, no pulse appears without a preceding sync.
- R7: While `tmr_en` is low, `adc_start` stays low and both counters are held at 0. A delay in progress is dropped, and after re-enable free-running timing starts afresh.
- R8: In free-running mode, `pwm_sync` has no effect on `adc_start`.
- R9: In free-running mode, `adc_start` never stays high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tmr_en | input | 1 | Channel enable; low holds counters at 0 |
| mode_sel | input | 1 | 0 = free-running, 1 = PWM-locked delay |
| period_val | input | CNT_W | Free-running period, in cycles minus one |
| delay_val | input | CNT_W | Delay from sync to trigger, in cycles |
| pwm_sync | input | 1 | PWM reload sync pulse |
| adc_start | output | 1 | One-cycle ADC start-of-conversion pulse |

## Verification
The hardest situation to reach from the ports is a sync that lands partway through a running delay, in particular on the last cycle before the delay would have fired. The bench therefore sweeps the second sync over every offset from 1 to D cycles after the first, and checks that only the restarted delay fires. It also drops the enable in the middle of a delay, to show that the pending pulse is discarded. Every sample in each sweep is compared against an arithmetically computed expected pulse position.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;
  typedef enum logic {
    TRIG_FREE = 1'b0,
    TRIG_SYNC = 1'b1
  } trig_mode_e;
endpackage

// File: rtl/adc_trig_free_gen.sv
module adc_trig_free_gen #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] period_val,
  output logic             fire
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] per_eff;

  always_comb begin
    per_eff = (period_val == '0) ? ONE : period_val;
    fire    = run && (cnt_q >= per_eff);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (!run)   cnt_q <= '0;
    else if (fire)   cnt_q <= '0;
    else             cnt_q <= cnt_q + ONE;
  end

  // R9
  single_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !fire);
  // R7
  free_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == '0));
endmodule

// File: rtl/adc_trig_sync_gen.sv
module adc_trig_sync_gen #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             sync_in,
  input  logic [CNT_W-1:0] delay_val,
  output logic             fire
);
  localparam int CW1 = CNT_W + 1;

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CW1-1:0]   cnt_nx;
  logic             reached;

  always_comb begin
    cnt_nx  = {1'b0, cnt_q} + CW1'(1);
    reached = busy_q && (cnt_nx >= {1'b0, delay_val});
    fire    = run && (sync_in ? (delay_val == '0) : reached);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!run) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (sync_in) begin
      busy_q <= (delay_val != '0);
      cnt_q  <= '0;
    end else if (reached) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (busy_q) begin
      cnt_q  <= cnt_nx[CNT_W-1:0];
    end
  end

  // R5
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && sync_in) |=> (cnt_q == '0));
  // R7
  sync_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!busy_q && cnt_q == '0));
  // R6
  no_idle_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !busy_q && !sync_in) |-> !fire);
endmodule

// File: rtl/adc_trig_pulse_out.sv
module adc_trig_pulse_out (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_sync,
  input  logic free_fire,
  input  logic sync_fire,
  output logic pulse
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse <= 1'b0;
    else        pulse <= sel_sync ? sync_fire : free_fire;
  end
endmodule

// File: rtl/adc_trig_delay_timer.sv
module adc_trig_delay_timer
  import adc_trig_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tmr_en,
  input  logic             mode_sel,
  input  logic [CNT_W-1:0] period_val,
  input  logic [CNT_W-1:0] delay_val,
  input  logic             pwm_sync,
  output logic             adc_start
);
  trig_mode_e mode;
  logic       run_free, run_sync;
  logic       free_fire, sync_fire;

  always_comb begin
    mode     = trig_mode_e'(mode_sel);
    run_free = tmr_en && (mode == TRIG_FREE);
    run_sync = tmr_en && (mode == TRIG_SYNC);
  end

  adc_trig_free_gen #(.CNT_W(CNT_W)) u_free (
    .clk(clk), .rst_n(rst_n), .run(run_free),
    .period_val(period_val), .fire(free_fire)
  );

  adc_trig_sync_gen #(.CNT_W(CNT_W)) u_sync (
    .clk(clk), .rst_n(rst_n), .run(run_sync), .sync_in(pwm_sync),
    .delay_val(delay_val), .fire(sync_fire)
  );

  adc_trig_pulse_out u_out (
    .clk(clk), .rst_n(rst_n), .sel_sync(run_sync),
    .free_fire(free_fire), .sync_fire(sync_fire), .pulse(adc_start)
  );

  // R7
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tmr_en |=> !adc_start);
  // R4
  zero_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_sync && pwm_sync && delay_val == '0) |=> adc_start);
  // R8
  free_ignores_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_free |-> !sync_fire);
endmodule

// File: tb/sim_adc_trig_delay_timer.sv
module sim_adc_trig_delay_timer;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tmr_en = 1'b0;
  logic mode_sel = 1'b0;
  logic [CNT_W-1:0] period_val = '0;
  logic [CNT_W-1:0] delay_val = '0;
  logic pwm_sync = 1'b0;
  logic adc_start;

  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  adc_trig_delay_timer #(.CNT_W(CNT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .tmr_en(tmr_en), .mode_sel(mode_sel),
    .period_val(period_val), .delay_val(delay_val),
    .pwm_sync(pwm_sync), .adc_start(adc_start)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input logic got, input logic exp, input string tag);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%0b exp=%0b t=%0t", tag, got, exp, $time);
    end
  endtask

  task automatic quiesce();
    tmr_en = 1'b0;
    pwm_sync = 1'b0;
    tick();
    tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    tick();
    chk(adc_start, 1'b0, "reset R7");
    tick();
    rst_n = 1'b1;
    tick();
    chk(adc_start, 1'b0, "post-reset R7");

    // R1 R2 R8 R9: free-running sweep with sync toggling
    for (int p = 0; p <= 7; p++) begin
      quiesce();
      mode_sel = 1'b0;
      period_val = CNT_W'(p);
      tmr_en = 1'b1;
      for (int n = 1; n <= 3 * ((p == 0 ? 1 : p) + 1); n++) begin
        int pe;
        pe = (p == 0) ? 1 : p;
        tick();
        pwm_sync = n[0];
        chk(adc_start, ((n % (pe + 1)) == 0), (p == 0) ? "R2 free p0" : "R1 R8 R9 free");
      end
    end

    // R3 R4 R6: single sync per delay value
    for (int d = 0; d <= 8; d++) begin
      quiesce();
      mode_sel = 1'b1;
      delay_val = CNT_W'(d);
      tmr_en = 1'b1;
      for (int n = 0; n < 4; n++) begin
        tick();
        chk(adc_start, 1'b0, "R6 idle");
      end
      pwm_sync = 1'b1;
      for (int n = 1; n <= d + 4; n++) begin
        tick();
        pwm_sync = 1'b0;
        chk(adc_start, (n == d + 1), (d == 0) ? "R4 zero delay" : "R3 delay");
      end
    end

    // R5: second sync at every offset inside the delay
    for (int d = 1; d <= 6; d++) begin
      for (int k = 1; k <= d; k++) begin
        quiesce();
        mode_sel = 1'b1;
        delay_val = CNT_W'(d);
        tmr_en = 1'b1;
        tick();
        pwm_sync = 1'b1;
        for (int n = 1; n <= k + d + 3; n++) begin
          tick();
          chk(adc_start, (n == k + d + 1), "R5 restart");
          pwm_sync = (n == k);
        end
      end
    end

    // R7: enable dropped mid-delay, pending pulse lost
    quiesce();
    mode_sel = 1'b1;
    delay_val = CNT_W'(6);
    tmr_en = 1'b1;
    tick();
    pwm_sync = 1'b1;
    tick();
    pwm_sync = 1'b0;
    tick();
    tmr_en = 1'b0;
    for (int n = 0; n < 8; n++) begin
      tick();
      pwm_sync = n[0];
      chk(adc_start, 1'b0, "R7 disabled");
    end
    pwm_sync = 1'b0;
    tmr_en = 1'b1;
    for (int n = 0; n < 10; n++) begin
      tick();
      chk(adc_start, 1'b0, "R7 dropped delay");
    end

    // R7: free mode restart after disable mid-count
    quiesce();
    mode_sel = 1'b0;
    period_val = CNT_W'(5);
    tmr_en = 1'b1;
    tick();
    tick();
    tick();
    tmr_en = 1'b0;
    tick();
    tmr_en = 1'b1;
    for (int n = 1; n <= 12; n++) begin
      tick();
      chk(adc_start, ((n % 6) == 0), "R7 free restart");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule